// File: doc/BRIEF.md
# Stereo Volume Attenuation Scaler

This block converts packed volume control words into one linear gain per stereo side and applies those gains to a stream of signed 16-bit left/right sample pairs. In playback mode two words take part: a master word and a PCM word. Each carries an attenuation level per side, and the two levels are combined into a single gain. In record mode one gain word is used directly. A mute bit in any word that takes part silences the stream.

The control words are sampled only when a load strobe is pulsed. Gains are then held in registers, and each sample pair picks up the gains present when the block accepts it. Changing the words between strobes therefore never splits a sample or alters a sample already in flight. Samples enter and leave through valid/ready handshakes and cross a two-register pipeline that can take one pair per cycle.

Top module: `stereo_gain_scaler`

## Requirements
- R1: Each control word carries mute in bit 15, the right-side level in bits [B-1:0] and the left-side level in bits [8+B-1:8], where B is 6 for master, 5 for PCM and 4 for record. All other bits have no effect on the gains.
- R2: A level field f with mask M = 2^B-1 normalises to floor(255*f/M). The result is 255 when the field is all ones and 0 when it is zero.
- R3: In playback mode each normalised master and PCM level is replaced by 255 minus itself, since these fields encode attenuation. In record mode the normalised record level is used unchanged.
- R4: The playback gain of each side is floor(master_gain*pcm_gain/255).
- R5: In playback mode the output is muted when the master or the PCM mute bit is 1. In record mode it is muted when the record mute bit is 1. A muted pair leaves as 0 on both sides.
- R6: Each output sample equals the input sample times its side's gain, divided by 255 and truncated toward zero. The two sides are scaled independently.
- R7: Gains and mute change only on a clock edge where cfg_load is 1. A pair accepted on that same edge still uses the previous gains. Changing the control words without cfg_load has no effect on the output.
- R8: cfg_mode is sampled with cfg_load. The value 0 selects playback (master and PCM words) and 1 selects record (record word).
- R9: After reset out_valid is 0 and in_ready is 1. Until the first cfg_load the block is muted with both gains 0, so any pair accepted before then comes out as zeros.
- R10: A pair accepted on clock edge k, with out_ready held at 1, is presented on the output after edge k+1. The block accepts one pair per cycle while out_ready stays 1.
- R11: While out_valid is 1 and out_ready is 0, the output pair and out_valid hold steady. Every accepted pair leaves exactly once, in order.
- R12: With both gains at 255 and mute clear, every sample passes through unchanged, including -32768 and 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Strobe: sample the control words and the mode |
| cfg_mode | input | 1 | 0 = playback, 1 = record |
| master_word | input | 16 | Master attenuation word |
| pcm_word | input | 16 | PCM attenuation word |
| rec_word | input | 16 | Record gain word |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block can accept a pair |
| in_left | input | 16 | Left input sample, two's complement |
| in_right | input | 16 | Right input sample, two's complement |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream accepts the pair |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |

## Verification
The assertions assume the downstream side obeys the handshake. They also assume cfg_load is not held high for long stretches of streaming, so the held-gain property stays meaningful. The sample and word inputs may take any value. The stimulus drives every input on the falling edge and raises cfg_load for a single cycle, and only between sample bursts. out_ready follows a fixed stall pattern during the backpressure burst, so the stability properties get exercised by real stalls.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
   localparam int WORD_W   = 16;
   localparam int MUTE_POS = 15;
   localparam int LEFT_LSB = 8;

   typedef enum logic {
      GSC_PLAYBACK = 1'b0,
      GSC_RECORD   = 1'b1
   } gsc_mode_e;

   localparam int SIDE_LEFT  = 0;
   localparam int SIDE_RIGHT = 1;
   localparam int NUM_SIDES  = 2;
endpackage

// File: rtl/gsc_field_norm.sv
module gsc_field_norm #(
   parameter int FIELD_BITS = 6,
   parameter int GAIN_W     = 8,
   parameter bit INVERT     = 1'b0
) (
   input  logic [FIELD_BITS-1:0] field,
   output logic [GAIN_W-1:0]     level
);
   localparam int FMASK  = (1 << FIELD_BITS) - 1;
   localparam int GMAX   = (1 << GAIN_W) - 1;
   localparam int PROD_W = FIELD_BITS + GAIN_W;

   logic [PROD_W-1:0] scaled;
   logic [PROD_W-1:0] quot;
   logic [GAIN_W-1:0] linear;

   always_comb begin
      scaled = PROD_W'(GMAX) * PROD_W'(field);
      quot   = scaled / PROD_W'(FMASK);
      linear = quot[GAIN_W-1:0];
   end

   generate
      if (INVERT) begin : g_atten
         assign level = GAIN_W'(GMAX) - linear;
      end else begin : g_gain
         assign level = linear;
      end
   endgenerate
endmodule

// File: rtl/gsc_gain_cfg.sv
module gsc_gain_cfg
   import gsc_pkg::*;
#(
   parameter int GAIN_W      = 8,
   parameter int MASTER_BITS = 6,
   parameter int PCM_BITS    = 5,
   parameter int REC_BITS    = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic                         mode,
   input  logic [WORD_W-1:0]            master_word,
   input  logic [WORD_W-1:0]            pcm_word,
   input  logic [WORD_W-1:0]            rec_word,
   output logic [NUM_SIDES-1:0][GAIN_W-1:0] gain,
   output logic                         mute
);
   localparam int GMAX  = (1 << GAIN_W) - 1;
   localparam int MUL_W = 2 * GAIN_W;

   logic [NUM_SIDES-1:0][GAIN_W-1:0] play_gain;
   logic [NUM_SIDES-1:0][GAIN_W-1:0] rec_gain;
   logic                             next_mute;

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
         localparam int LSB = (s == SIDE_LEFT) ? LEFT_LSB : 0;
         logic [GAIN_W-1:0] m_lvl;
         logic [GAIN_W-1:0] p_lvl;
         logic [MUL_W-1:0]  mp_prod;
         logic [MUL_W-1:0]  mp_quot;

         gsc_field_norm #(.FIELD_BITS(MASTER_BITS), .GAIN_W(GAIN_W), .INVERT(1'b1)) u_master (
            .field(master_word[LSB +: MASTER_BITS]),
            .level(m_lvl)
         );
         gsc_field_norm #(.FIELD_BITS(PCM_BITS), .GAIN_W(GAIN_W), .INVERT(1'b1)) u_pcm (
            .field(pcm_word[LSB +: PCM_BITS]),
            .level(p_lvl)
         );
         gsc_field_norm #(.FIELD_BITS(REC_BITS), .GAIN_W(GAIN_W), .INVERT(1'b0)) u_rec (
            .field(rec_word[LSB +: REC_BITS]),
            .level(rec_gain[s])
         );

         always_comb begin
            mp_prod      = MUL_W'(m_lvl) * MUL_W'(p_lvl);
            mp_quot      = mp_prod / MUL_W'(GMAX);
            play_gain[s] = mp_quot[GAIN_W-1:0];
         end
      end
   endgenerate

   always_comb begin
      if (gsc_mode_e'(mode) == GSC_RECORD) next_mute = rec_word[MUTE_POS];
      else next_mute = master_word[MUTE_POS] | pcm_word[MUTE_POS];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain <= '0;
         mute <= 1'b1;
      end else if (load) begin
         gain <= (gsc_mode_e'(mode) == GSC_RECORD) ? rec_gain : play_gain;
         mute <= next_mute;
      end
   end

   // Gains only move on a load strobe
   assert_gain_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(gain) && $stable(mute)));

   // A full-scale record field gives full gain on the right side
   assert_rec_fullscale_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && mode && (&rec_word[REC_BITS-1:0])) |=> (gain[SIDE_RIGHT] == GAIN_W'(GMAX)));

   // Either playback mute bit silences
   assert_play_mute_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !mode && (master_word[MUTE_POS] || pcm_word[MUTE_POS])) |=> mute);
endmodule

// File: rtl/gsc_side_scale.sv
module gsc_side_scale #(
   parameter int SAMPLE_W = 16,
   parameter int GAIN_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take1,
   input  logic                take2,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic [GAIN_W-1:0]   gain_in,
   input  logic                mute_in,
   output logic [SAMPLE_W-1:0] sample_out
);
   localparam int GMAX = (1 << GAIN_W) - 1;
   localparam int PW   = SAMPLE_W + GAIN_W + 1;

   logic signed [PW-1:0]   s1_prod;
   logic                   s1_mute;
   logic                   s1_unity;
   logic [SAMPLE_W-1:0]    s1_sample;
   logic signed [PW-1:0]   mul_now;
   logic [PW-1:0]          mag;
   logic [PW-1:0]          mag_q;
   logic [PW-1:0]          signed_q;

   assign mul_now = PW'($signed(sample_in)) * PW'($signed({1'b0, gain_in}));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_prod   <= '0;
         s1_mute   <= 1'b1;
         s1_unity  <= 1'b0;
         s1_sample <= '0;
      end else if (take1) begin
         s1_prod   <= mul_now;
         s1_mute   <= mute_in;
         s1_unity  <= (gain_in == GAIN_W'(GMAX));
         s1_sample <= sample_in;
      end
   end

   always_comb begin
      mag      = s1_prod[PW-1] ? PW'(-s1_prod) : PW'(s1_prod);
      mag_q    = mag / PW'(GMAX);
      signed_q = s1_prod[PW-1] ? (~mag_q + PW'(1)) : mag_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sample_out <= '0;
      else if (take2) sample_out <= s1_mute ? '0 : signed_q[SAMPLE_W-1:0];
   end

   function automatic logic [SAMPLE_W:0] absval(input logic [SAMPLE_W-1:0] v);
      return v[SAMPLE_W-1] ? (SAMPLE_W+1)'(-$signed({v[SAMPLE_W-1], v})) : {1'b0, v};
   endfunction

   assert_unity_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (take2 && s1_unity && !s1_mute) |=> (sample_out == $past(s1_sample)));

   assert_muted_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take2 && s1_mute) |=> (sample_out == '0));

   assert_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take2 |=> (absval(sample_out) <= absval($past(s1_sample))));
endmodule

// File: rtl/stereo_gain_scaler.sv
module stereo_gain_scaler
   import gsc_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int GAIN_W      = 8,
   parameter int MASTER_BITS = 6,
   parameter int PCM_BITS    = 5,
   parameter int REC_BITS    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_load,
   input  logic                cfg_mode,
   input  logic [WORD_W-1:0]   master_word,
   input  logic [WORD_W-1:0]   pcm_word,
   input  logic [WORD_W-1:0]   rec_word,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [SAMPLE_W-1:0] out_left,
   output logic [SAMPLE_W-1:0] out_right
);
   localparam int WIDEST = (MASTER_BITS > PCM_BITS) ?
                           ((MASTER_BITS > REC_BITS) ? MASTER_BITS : REC_BITS) :
                           ((PCM_BITS > REC_BITS) ? PCM_BITS : REC_BITS);

   generate
      if (WIDEST > LEFT_LSB) begin : g_bad_field
         $error("level fields must fit below the left-side field start");
      end
      if (MASTER_BITS < 1 || PCM_BITS < 1 || REC_BITS < 1) begin : g_bad_min
         $error("level fields need at least one bit");
      end
      if (GAIN_W < 2 || GAIN_W > 12) begin : g_bad_gain
         $error("gain width out of supported range");
      end
      if (SAMPLE_W < 2) begin : g_bad_sample
         $error("sample width too small");
      end
   endgenerate

   logic [NUM_SIDES-1:0][GAIN_W-1:0]   gain;
   logic                               mute;
   logic                               s1_v;
   logic                               s2_v;
   logic                               s2_open;
   logic                               in_fire;
   logic                               adv2;
   logic [NUM_SIDES-1:0][SAMPLE_W-1:0] lane_in;
   logic [NUM_SIDES-1:0][SAMPLE_W-1:0] lane_out;

   gsc_gain_cfg #(
      .GAIN_W(GAIN_W), .MASTER_BITS(MASTER_BITS), .PCM_BITS(PCM_BITS), .REC_BITS(REC_BITS)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .mode(cfg_mode),
      .master_word(master_word), .pcm_word(pcm_word), .rec_word(rec_word),
      .gain(gain), .mute(mute)
   );

   assign s2_open  = !s2_v || out_ready;
   assign in_ready = !s1_v || s2_open;
   assign in_fire  = in_valid && in_ready;
   assign adv2     = s1_v && s2_open;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0;
         s2_v <= 1'b0;
      end else begin
         if (in_fire) s1_v <= 1'b1;
         else if (adv2) s1_v <= 1'b0;
         if (adv2) s2_v <= 1'b1;
         else if (out_ready) s2_v <= 1'b0;
      end
   end

   assign lane_in[SIDE_LEFT]  = in_left;
   assign lane_in[SIDE_RIGHT] = in_right;

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_lane
         gsc_side_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .take1(in_fire), .take2(adv2),
            .sample_in(lane_in[s]), .gain_in(gain[s]), .mute_in(mute),
            .sample_out(lane_out[s])
         );
      end
   endgenerate

   assign out_valid = s2_v;
   assign out_left  = lane_out[SIDE_LEFT];
   assign out_right = lane_out[SIDE_RIGHT];

   assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

   assert_empty_accepts_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   assert_fill_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(s1_v));
endmodule

// File: tb/sim_stereo_gain_scaler.sv
module sim_stereo_gain_scaler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic        cfg_mode = 1'b0;
   logic [15:0] master_word = '0;
   logic [15:0] pcm_word = '0;
   logic [15:0] rec_word = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_left = '0;
   logic [15:0] in_right = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_left;
   logic [15:0] out_right;

   int  n_tests = 0;
   int  n_fail = 0;
   bit  stall_on = 1'b0;
   int  cyc = 0;
   bit  finished = 1'b0;

   int  gl = 0, gr = 0;
   bit  gmute = 1'b1;

   typedef struct {
      int    l;
      int    r;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   stereo_gain_scaler u0 (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
      .master_word(master_word), .pcm_word(pcm_word), .rec_word(rec_word),
      .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
      .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
   );

   function automatic int norm(int field, int mask, bit inv);
      int v;
      v = (255 * field) / mask;
      return inv ? 255 - v : v;
   endfunction

   function automatic int scale(int s, int g, bit m);
      if (m) return 0;
      return (s * g) / 255;
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      cyc <= cyc + 1;
      out_ready <= stall_on ? ((cyc % 3) != 1) : 1'b1;
   end

   // monitor / scoreboard
   bit          hold_prev = 1'b0;
   logic [15:0] prev_l, prev_r;
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (hold_prev) begin
               check(out_valid && out_left == prev_l && out_right == prev_r, "R11",
                     int'(out_left), int'(prev_l));
            end
            if (out_valid && out_ready) begin
               if (sb.size() == 0) begin
                  check(1'b0, "R11 unexpected output", int'(out_left), 0);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  check(int'($signed(out_left)) == e.l, {e.tag, " left"},
                        int'($signed(out_left)), e.l);
                  check(int'($signed(out_right)) == e.r, {e.tag, " right"},
                        int'($signed(out_right)), e.r);
               end
            end
            hold_prev = out_valid && !out_ready;
            prev_l = out_left;
            prev_r = out_right;
         end
      end
   end

   task automatic cfg(bit rec, logic [15:0] mw, logic [15:0] pw, logic [15:0] rw);
      @(negedge clk);
      cfg_mode = rec; master_word = mw; pcm_word = pw; rec_word = rw; cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      if (rec) begin
         gl = norm(int'(rw[11:8]), 15, 1'b0);
         gr = norm(int'(rw[3:0]), 15, 1'b0);
         gmute = rw[15];
      end else begin
         gl = (norm(int'(mw[13:8]), 63, 1'b1) * norm(int'(pw[12:8]), 31, 1'b1)) / 255;
         gr = (norm(int'(mw[5:0]), 63, 1'b1) * norm(int'(pw[4:0]), 31, 1'b1)) / 255;
         gmute = mw[15] | pw[15];
      end
   endtask

   task automatic send(int l, int r, string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; in_left = 16'(l); in_right = 16'(r);
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      e.l = scale(l, gl, gmute);
      e.r = scale(r, gr, gmute);
      e.tag = tag;
      sb.push_back(e);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
      check(sb.size() == 0, "R11 drain", sb.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9: reset state at the ports
      check(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
      check(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
      // R9: muted with zero gains before any load
      send(12345, -2000, "R9");
      drain();

      // R12/R8: record full-scale passes samples through
      cfg(1'b1, 16'h0000, 16'h0000, 16'h0F0F);
      send(-32768, 32767, "R12");
      send(-1, 1, "R12");
      send(0, -12345, "R12");
      drain();

      // R1/R2/R6: asymmetric record fields (left 3 -> 51, right 5 -> 85)
      cfg(1'b1, 16'h0000, 16'h0000, 16'h0305);
      send(1000, 1000, "R6");
      send(-32768, -32768, "R2");
      send(-7, 7, "R6");
      drain();

      // R3/R4: playback combined gain
      cfg(1'b0, 16'h0000, 16'h0808, 16'h0000);
      send(-32768, 32767, "R4");
      send(-3001, 3001, "R3");
      cfg(1'b0, 16'h0A14, 16'h0000, 16'h0F0F);
      send(20000, 20000, "R3");
      send(-20000, -20000, "R4");
      drain();

      // R1: bits outside the fields ignored (only max attenuation remains)
      cfg(1'b0, 16'h7FFF, 16'h60E0, 16'h0000);
      send(30000, -30000, "R1");
      cfg(1'b0, 16'h40C0, 16'h6000, 16'h0000);
      send(-30000, 30000, "R1");
      drain();

      // R5: mute from either playback word, and record mute
      cfg(1'b0, 16'h8000, 16'h0000, 16'h0F0F);
      send(5000, -5000, "R5 master mute");
      cfg(1'b0, 16'h0000, 16'h8000, 16'h0F0F);
      send(5000, -5000, "R5 pcm mute");
      cfg(1'b1, 16'h0000, 16'h0000, 16'h8F0F);
      send(5000, -5000, "R5 rec mute");
      drain();

      // R7: words change without a load -> no effect
      cfg(1'b1, 16'h0000, 16'h0000, 16'h0A06);
      @(negedge clk);
      rec_word = 16'h0F0F; master_word = 16'h8000; cfg_mode = 1'b0;
      send(10000, -10000, "R7");
      drain();

      // R10: two-edge latency
      stall_on = 1'b0;
      repeat (2) @(negedge clk);
      send(321, -321, "R10");
      check(out_valid == 1'b0, "R10 latency early", int'(out_valid), 0);
      @(posedge clk);
      #2;
      check(out_valid == 1'b1, "R10 latency", int'(out_valid), 1);
      drain();

      // R10/R11: back-to-back stream with downstream stalls
      cfg(1'b0, 16'h0102, 16'h0304, 16'h0000);
      stall_on = 1'b1;
      for (int i = 0; i < 24; i++) begin
         send((i * 2731) - 32768, 32767 - (i * 1999), "R11 stream");
      end
      drain();
      stall_on = 1'b0;

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule